// File: doc/BRIEF.md
# Key-Event Controller I2C Slave Port

This block is the host-facing serial port of a key-event controller. It watches a two-wire I2C bus, and it answers only when the 7-bit address is binary 01000 in the top five bits with two strap inputs as the low bits. A host write reaches exactly one control byte. The host uses that byte to enable the sense drive output and to request power-down with full reset.

A host read always returns the same four-byte stream. The bytes come in this order: a fixed chip identifier, the control byte, the key code at the head of the event FIFO, and the duration byte that belongs to that key. The block reads the FIFO head through a peek interface and pulses an advance strobe only when the master acknowledges the duration byte. A master that ends with a NACK therefore sees the same event on its next read.

Both bus lines pass through a synchronizer and a glitch filter before any edge is detected. The block pulls SDA low through an open-drain enable and never releases SCL.

Top module: `kc_i2c_keyslave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {5'b01000, addr_sel}. A byte that does not match gets no acknowledge, and every byte after it up to the next START or STOP is ignored.
- R2: In a write, the first data byte is acknowledged and loads drive_en from bit 7 and pwrdn_req from bit 6. Bits 5 to 0 of that byte have no effect.
- R3: A second or later data byte in the same write is not acknowledged and leaves the control bits unchanged.
- R4: A read returns, MSB first, the chip ID 0x00, then the control byte, then the key byte, then the duration byte.
- R5: The control byte reads back as {drive_en, pwrdn_req, fifo_empty, 5'b00000}. Bit 5 follows fifo_empty.
- R6: After reset, drive_en is 1, pwrdn_req is 0, sda_oe is 0, fifo_adv is 0, and a read returns control byte 0x80 with bit 5 set from fifo_empty.
- R7: A master ACK on the duration byte gives exactly one single-cycle fifo_adv pulse. A NACK on it, or a read that stops earlier, gives none.
- R8: The key and duration values are captured together when the key byte starts. Changes on fifo_key and fifo_dur after that point do not alter the bytes of that read.
- R9: A START at any point, including inside a byte, abandons the transfer in progress and begins a new address phase. A STOP releases SDA.
- R10: SDA is pulled low only while the filtered SCL is low, and each filtered line changes only to a value its synchronizer has presented for the filter length.
- R11: drive_en and pwrdn_req hold their written values until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Strap value for the two address LSBs |
| fifo_key | input | 8 | Key code at the FIFO head |
| fifo_dur | input | 8 | Duration byte at the FIFO head |
| fifo_empty | input | 1 | FIFO holds no unread event |
| fifo_adv | output | 1 | One-cycle strobe that moves the FIFO read pointer |
| drive_en | output | 1 | Control bit 7: sense drive output active |
| pwrdn_req | output | 1 | Control bit 6: power-down and full reset request |

## Verification
A bus edge at the pins reaches the engine about six system clocks later: two synchronizer flops, the filter count and one event register. SDA drive and the fifo_adv strobe appear one clock after the filtered edge. The bench moves each bus line only once every 20 clocks. It reads SDA in the middle of the SCL-high phase and checks the control outputs and the strobe count only after STOP, so every result has settled well before it is sampled. The check on captured key and duration changes the FIFO inputs one bit into the key byte, which is after the capture point and before the byte ends.

// File: rtl/kc_pkg.sv
package kc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_SKIP
    } kc_state_e;

    typedef struct packed {
        kc_state_e   st;
        logic [2:0]  bit_cnt;
        logic        byte_full;
        logic [7:0]  shreg;
        logic [1:0]  byte_idx;
        logic        rw;
        logic        mst_ack;
        logic        wr_done;
        logic        sda_oe;
        logic        adv;
        logic        drv_en;
        logic        pwrdn;
        logic [7:0]  dur_hold;
    } kc_eng_s;

endpackage

// File: rtl/kc_line_filter.sv
module kc_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_LEN-1:0] sync_d, sync_q;
    logic [CW-1:0]       cnt_d, cnt_q;
    logic                filt_d, filt_q;

    always_comb begin
        sync_d = {sync_q[SYNC_LEN-2:0], raw_i};
        cnt_d  = cnt_q;
        filt_d = filt_q;
        if (sync_q[SYNC_LEN-1] == filt_q) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            filt_d = sync_q[SYNC_LEN-1];
            cnt_d  = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    assign filt_o = filt_q;

    AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> $past(sync_q[SYNC_LEN-1]) == filt_q) else $error("filter glitch"); // R10

endmodule

// File: rtl/kc_bus_events.sv
module kc_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_f;
        sda_d = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_rise = !scl_q && scl_f;
    assign scl_fall = scl_q && !scl_f;
    assign start_ev = scl_q && scl_f && sda_q && !sda_f;
    assign stop_ev  = scl_q && scl_f && !sda_q && sda_f;

endmodule

// File: rtl/kc_xfer_engine.sv
module kc_xfer_engine
    import kc_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h00,
    parameter logic [4:0] ADDR_HI = 5'b01000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       scl_lvl,
    input  logic       sda_in,
    input  logic [1:0] addr_sel,
    input  logic [7:0] fifo_key,
    input  logic [7:0] fifo_dur,
    input  logic       fifo_empty,
    output logic       sda_oe,
    output logic       fifo_adv,
    output logic       drv_en,
    output logic       pwrdn
);
    localparam logic [1:0] LAST_IDX = 2'd3;

    kc_eng_s    q, n;
    logic [7:0] ld_byte;

    always_comb begin
        n       = q;
        n.adv   = 1'b0;
        ld_byte = 8'h00;
        if (stop_ev) begin
            n.st     = ST_IDLE;
            n.sda_oe = 1'b0;
        end else if (start_ev) begin
            n.st        = ST_ADDR;
            n.bit_cnt   = 3'd0;
            n.byte_full = 1'b0;
            n.wr_done   = 1'b0;
            n.sda_oe    = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise) begin
                        n.shreg   = {q.shreg[6:0], sda_in};
                        n.bit_cnt = q.bit_cnt + 3'd1;
                        if (q.bit_cnt == 3'd7) n.byte_full = 1'b1;
                    end else if (scl_fall && q.byte_full) begin
                        n.byte_full = 1'b0;
                        n.bit_cnt   = 3'd0;
                        n.st        = ST_SKIP;
                        if (q.st == ST_ADDR) begin
                            if (q.shreg[7:1] == {ADDR_HI, addr_sel}) begin
                                n.rw     = q.shreg[0];
                                n.sda_oe = 1'b1;
                                n.st     = ST_ADDR_ACK;
                            end
                        end else if (!q.wr_done) begin
                            n.drv_en  = q.shreg[7];
                            n.pwrdn   = q.shreg[6];
                            n.wr_done = 1'b1;
                            n.sda_oe  = 1'b1;
                            n.st      = ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            n.byte_idx = 2'd0;
                            n.shreg    = CHIP_ID;
                            n.sda_oe   = !CHIP_ID[7];
                            n.bit_cnt  = 3'd0;
                            n.st       = ST_RD_DATA;
                        end else begin
                            n.sda_oe = 1'b0;
                            n.st     = ST_WR_DATA;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        n.sda_oe = 1'b0;
                        n.st     = ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (q.bit_cnt == 3'd7) begin
                            n.sda_oe = 1'b0;
                            n.st     = ST_RD_ACK;
                        end else begin
                            n.shreg   = {q.shreg[6:0], 1'b1};
                            n.sda_oe  = !q.shreg[6];
                            n.bit_cnt = q.bit_cnt + 3'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        n.mst_ack = !sda_in;
                        if (!sda_in && q.byte_idx == LAST_IDX) n.adv = 1'b1;
                    end else if (scl_fall) begin
                        if (!q.mst_ack || q.byte_idx == LAST_IDX) begin
                            n.st = ST_SKIP;
                        end else begin
                            case (q.byte_idx)
                                2'd0: ld_byte = {q.drv_en, q.pwrdn, fifo_empty, 5'b00000};
                                2'd1: begin
                                    ld_byte    = fifo_key;
                                    n.dur_hold = fifo_dur;
                                end
                                default: ld_byte = q.dur_hold;
                            endcase
                            n.byte_idx = q.byte_idx + 2'd1;
                            n.bit_cnt  = 3'd0;
                            n.shreg    = ld_byte;
                            n.sda_oe   = !ld_byte[7];
                            n.st       = ST_RD_DATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.drv_en <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign sda_oe   = q.sda_oe;
    assign fifo_adv = q.adv;
    assign drv_en   = q.drv_en;
    assign pwrdn    = q.pwrdn;

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && $past(q.st) == ST_ADDR) |-> $past(q.shreg[7:1]) == {ADDR_HI, addr_sel}) else $error("ack mismatch"); // R1
    AST_CTRL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(drv_en) || !$stable(pwrdn)) |-> $past(q.st) == ST_WR_DATA) else $error("ctrl changed"); // R11
    AST_ADV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_adv |=> !fifo_adv) else $error("adv width"); // R7
    AST_ADV_AFTER_DUR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_adv |-> (q.st == ST_RD_ACK && q.byte_idx == LAST_IDX)) else $error("adv place"); // R7
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl) else $error("sda while scl high"); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe) else $error("held after stop"); // R9

endmodule

// File: rtl/kc_i2c_keyslave.sv
module kc_i2c_keyslave #(
    parameter int         SYNC_LEN = 2,
    parameter int         FILT_LEN = 3,
    parameter logic [7:0] CHIP_ID  = 8'h00,
    parameter logic [4:0] ADDR_HI  = 5'b01000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_sel,
    input  logic [7:0] fifo_key,
    input  logic [7:0] fifo_dur,
    input  logic       fifo_empty,
    output logic       fifo_adv,
    output logic       drive_en,
    output logic       pwrdn_req
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        kc_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    kc_bus_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[1]),
        .sda_f    (filt_lines[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    kc_xfer_engine #(.CHIP_ID(CHIP_ID), .ADDR_HI(ADDR_HI)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_ev   (start_ev),
        .stop_ev    (stop_ev),
        .scl_lvl    (filt_lines[1]),
        .sda_in     (filt_lines[0]),
        .addr_sel   (addr_sel),
        .fifo_key   (fifo_key),
        .fifo_dur   (fifo_dur),
        .fifo_empty (fifo_empty),
        .sda_oe     (sda_oe),
        .fifo_adv   (fifo_adv),
        .drv_en     (drive_en),
        .pwrdn      (pwrdn_req)
    );

endmodule

// File: tb/kc_i2c_keyslave_tb.sv
module kc_i2c_keyslave_tb;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_line, sda_oe;
    logic [1:0] addr_sel = 2'd0;
    logic [7:0] fifo_key = 8'h00, fifo_dur = 8'h00;
    logic fifo_empty = 1'b1;
    logic fifo_adv, drive_en, pwrdn_req;
    int tests = 0, fails = 0, adv_cnt = 0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    kc_i2c_keyslave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .fifo_key(fifo_key), .fifo_dur(fifo_dur),
        .fifo_empty(fifo_empty), .fifo_adv(fifo_adv), .drive_en(drive_en),
        .pwrdn_req(pwrdn_req)
    );

    always @(posedge clk) if (fifo_adv) adv_cnt = adv_cnt + 1;

    // {write byte, key, duration, empty, master acks duration}
    localparam logic [25:0] VEC [4] = '{
        {8'hC0, 8'h12, 8'h05, 1'b0, 1'b1},
        {8'h3F, 8'h00, 8'h80, 1'b1, 1'b1},
        {8'h5A, 8'hFF, 8'h7F, 1'b0, 1'b0},
        {8'h80, 8'hA5, 8'h3C, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; half(); m_scl = 1'b1; half(); half(); m_scl = 1'b0; half();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); b = sda_line; half(); m_scl = 1'b0; half();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(!mack);
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [7:0] d,
                            output logic a_ack, output logic d_ack);
        bus_start();
        send_byte({5'b01000, sel, 1'b0}, a_ack);
        send_byte(d, d_ack);
        bus_stop();
    endtask

    task automatic do_read(input logic [1:0] sel, input logic ack_last,
                           output logic a_ack, output logic [31:0] bytes, output int advs);
        int base;
        logic [7:0] b;
        base = adv_cnt;
        bus_start();
        send_byte({5'b01000, sel, 1'b1}, a_ack);
        for (int k = 0; k < 4; k++) begin
            recv_byte(b, (k < 3) ? 1'b1 : ack_last);
            bytes = {bytes[23:0], b};
        end
        bus_stop();
        half();
        advs = adv_cnt - base;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic aa, da, x;
        logic [31:0] rb;
        logic [7:0] kb, db, cb;
        int advs;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6 reset state
        chk("R6 drive_en", drive_en, 1);
        chk("R6 pwrdn_req", pwrdn_req, 0);
        chk("R6 sda_oe", sda_oe, 0);
        chk("R6 fifo_adv", fifo_adv, 0);
        do_read(2'd0, 1'b0, aa, rb, advs);
        chk("R6 reset ctrl readback", rb[23:16], 8'hA0);

        // table walk: R1 R2 R4 R5 R7 R11
        for (int i = 0; i < 4; i++) begin
            logic [7:0] wv;
            logic [1:0] sel;
            sel = 2'(i);
            wv = VEC[i][25:18];
            addr_sel = sel;
            fifo_key = VEC[i][17:10];
            fifo_dur = VEC[i][9:2];
            fifo_empty = VEC[i][1];
            do_write(sel, wv, aa, da);
            chk("R1 write address ack", aa, 1);
            chk("R2 data ack", da, 1);
            chk("R11 drive_en", drive_en, wv[7]);
            chk("R11 pwrdn_req", pwrdn_req, wv[6]);
            do_read(sel, VEC[i][0], aa, rb, advs);
            chk("R1 read address ack", aa, 1);
            chk("R4 chip id", rb[31:24], 8'h00);
            chk("R5 ctrl byte", rb[23:16], {wv[7:6], VEC[i][1], 5'b0});
            chk("R4 key byte", rb[15:8], VEC[i][17:10]);
            chk("R4 duration byte", rb[7:0], VEC[i][9:2]);
            chk("R7 advance count", advs, VEC[i][0] ? 1 : 0);
        end

        // R1 wrong address: no ack, data ignored
        addr_sel = 2'd0;
        do_write(2'd1, 8'h40, aa, da);
        chk("R1 mismatch no ack", aa, 0);
        chk("R1 data after mismatch no ack", da, 0);
        chk("R1 drive_en untouched", drive_en, 1);
        chk("R1 pwrdn untouched", pwrdn_req, 0);

        // R3 second byte of a write
        bus_start();
        send_byte({5'b01000, 2'd0, 1'b0}, aa);
        send_byte(8'h00, da);
        chk("R3 first byte ack", da, 1);
        send_byte(8'hC0, da);
        chk("R3 second byte nack", da, 0);
        bus_stop();
        chk("R3 drive_en from first", drive_en, 0);
        chk("R3 pwrdn from first", pwrdn_req, 0);

        // R9 repeated START inside an address byte
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte({5'b01000, 2'd0, 1'b0}, aa);
        send_byte(8'h80, da);
        bus_stop();
        chk("R9 ack after abort", aa & da, 1);
        chk("R9 write after abort", drive_en, 1);
        chk("R9 sda released after stop", sda_oe, 0);

        // R8 capture of key and duration at key byte start
        fifo_key = 8'h5C; fifo_dur = 8'h21; fifo_empty = 1'b0;
        bus_start();
        send_byte({5'b01000, 2'd0, 1'b1}, aa);
        recv_byte(cb, 1'b1);
        recv_byte(cb, 1'b1);
        recv_bit(kb[7]);
        fifo_key = 8'h00; fifo_dur = 8'hEE;
        for (int i = 6; i >= 0; i--) recv_bit(kb[i]);
        send_bit(1'b0);
        recv_byte(db, 1'b0);
        bus_stop();
        chk("R8 key held", kb, 8'h5C);
        chk("R8 duration held", db, 8'h21);
        x = 1'b0;
        chk("R8 sda idle", sda_oe, x);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule